// File: doc/BRIEF.md
# Asynchronous NAND Bus Front End

This block is the device-side decoder for an 8-bit asynchronous NAND-style bus. It runs in a fast system clock. Every bus pin passes through a synchroniser, and the block detects pin edges in the system clock domain.

**Write path.** The rising edge of the active-low write strobe is the byte clock. On that edge the block sorts the byte on the bus by the two latch-enable levels:

- command latch high: command byte
- address latch high: address byte
- both low: write data
- both high: protocol error

Commands and data go out on one-cycle strobes. Address bytes are collected into a multi-byte address register. While write protect is asserted, the block drops program and erase commands.

**Read path.** Each falling edge of the active-low read strobe pops the next byte from an internal page buffer and places it on the outbound bus. The bus is driven only while chip enable and read enable are both low. While chip enable is high, the block ignores all strobes.

Top module: `nand_bus_front`

## Requirements
- R1: While rst_ni is low, every strobe output is 0, io_oe_o is 0, io_o is 0, addr_o is 0 and addr_cnt_o is 0.
- R2: A write-enable rise with cle_i=1, ale_i=0 and chip enable low produces cmd_valid_o for exactly one clock, with cmd_o equal to the bus byte. The output changes after the clock edge that comes SYNC_STAGES edges after the first edge that samples the new pin levels.
- R3: A write-enable rise with ale_i=1, cle_i=0 stores the byte into address lane addr_cnt_o (lane k occupies bits 8k+7:8k, first byte in lane 0), increments addr_cnt_o and pulses addr_valid_o. The latency is the same as in R2.
- R4: Any captured command byte, including a suppressed one, clears addr_o and addr_cnt_o. Once addr_cnt_o equals ADDR_BYTES, further address bytes are discarded: no addr_valid_o, and no change to addr_o or addr_cnt_o.
- R5: A write-enable rise with cle_i=0 and ale_i=0 produces data_valid_o for one clock, with data_o equal to the byte.
- R6: A write-enable rise with cle_i=1 and ale_i=1 produces proto_err_o for one clock. No command, address or data strobe follows, and the address state is unchanged.
- R7: While ce_ni is high, write-enable and read-enable edges have no effect and io_oe_o stays low.
- R8: A read-enable fall with chip enable low pulses rd_pop_o for one clock and loads io_o with rd_data_i. Successive falls return successive buffer bytes. io_o holds its value between strobes.
- R9: io_oe_o is 1 exactly when the synchronised ce_ni and re_ni are both low, with the latency of R2.
- R10: While wp_ni is low, command bytes 0x80, 0x10, 0x60 and 0xD0 produce no cmd_valid_o. Other commands, including the status command 0x70, pass through.
- R11: At most one of cmd_valid_o, addr_valid_o, data_valid_o and proto_err_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| we_ni | input | 1 | Write strobe, byte captured on its rise |
| re_ni | input | 1 | Read strobe, byte popped on its fall |
| wp_ni | input | 1 | Write protect, active low |
| io_i | input | 8 | Inbound bus byte |
| io_o | output | 8 | Outbound bus byte |
| io_oe_o | output | 1 | Bus output enable |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_o | output | 8 | Command byte |
| addr_valid_o | output | 1 | Accepted address byte strobe |
| addr_o | output | 8*ADDR_BYTES | Collected address |
| addr_cnt_o | output | clog2(ADDR_BYTES+1) | Address bytes collected |
| data_valid_o | output | 1 | Write data strobe |
| data_o | output | 8 | Write data byte |
| proto_err_o | output | 1 | Both latch enables high at capture |
| rd_pop_o | output | 1 | Advance page buffer read pointer |
| rd_data_i | input | 8 | Current page buffer byte |

## Verification
The bench builds the block with SYNC_STAGES=2 and ADDR_BYTES=5. A cycle model keeps a pin history whose depth follows SYNC_STAGES, so the model tracks each edge at the exact clock where the design responds to it. With five address lanes, a full address followed by a sixth byte is a short sequence, which exercises the overflow discard. Write-protect toggles, chip-enable-high strobes and both-latches-high captures are mixed into the same sequence, so command suppression and address clearing are checked against whatever address state came before them.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_ADDR = 2'd2,
    KIND_BAD  = 2'd3
  } byte_kind_e;

  localparam logic [BYTE_W-1:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [BYTE_W-1:0] OP_PROG_GO     = 8'h10;
  localparam logic [BYTE_W-1:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [BYTE_W-1:0] OP_ERASE_GO    = 8'hD0;

  function automatic logic is_write_op(input logic [BYTE_W-1:0] b);
    return (b == OP_PROG_SETUP) || (b == OP_PROG_GO) ||
           (b == OP_ERASE_SETUP) || (b == OP_ERASE_GO);
  endfunction

  function automatic byte_kind_e classify(input logic cle, input logic ale);
    case ({cle, ale})
      2'b10:   return KIND_CMD;
      2'b01:   return KIND_ADDR;
      2'b11:   return KIND_BAD;
      default: return KIND_DATA;
    endcase
  endfunction
endpackage

// File: rtl/nand_fe_sync.sv
module nand_fe_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

  initial begin
    AST_SYNC_DEPTH: assert (STAGES >= 2) else $error("sync depth below 2"); // R2
  end
endmodule

// File: rtl/nand_fe_capture.sv
module nand_fe_capture
  import nand_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_s_i,
  input  logic              we_s_i,
  input  logic              cle_s_i,
  input  logic              ale_s_i,
  input  logic              wp_s_i,
  input  logic [BYTE_W-1:0] io_s_i,
  output logic              fire_cmd_o,
  output logic              fire_addr_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              data_valid_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              err_o
);
  logic       we_prev_q;
  logic       fire;
  logic       blocked;
  byte_kind_e kind;

  assign fire    = ~ce_s_i & we_s_i & ~we_prev_q;
  assign kind    = classify(cle_s_i, ale_s_i);
  // write-protect gate: status and other commands still pass
  assign blocked = ~wp_s_i & is_write_op(io_s_i);

  assign fire_cmd_o  = fire & (kind == KIND_CMD);
  assign fire_addr_o = fire & (kind == KIND_ADDR);
  assign byte_o      = io_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_prev_q    <= 1'b1;
      cmd_valid_o  <= 1'b0;
      cmd_o        <= '0;
      data_valid_o <= 1'b0;
      data_o       <= '0;
      err_o        <= 1'b0;
    end else begin
      we_prev_q    <= we_s_i;
      cmd_valid_o  <= fire_cmd_o & ~blocked;
      data_valid_o <= fire & (kind == KIND_DATA);
      err_o        <= fire & (kind == KIND_BAD);
      if (fire_cmd_o && !blocked) cmd_o <= io_s_i;
      if (fire && kind == KIND_DATA) data_o <= io_s_i;
    end
  end

  AST_CMD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o); // R2
  AST_DATA_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o); // R5
  AST_WP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !$past(wp_s_i)) |-> !is_write_op(cmd_o)); // R10
endmodule

// File: rtl/nand_fe_addr.sv
module nand_fe_addr
  import nand_fe_pkg::*;
#(
  parameter int N     = 5,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_cmd_i,
  input  logic                fire_addr_i,
  input  logic [BYTE_W-1:0]   byte_i,
  output logic [N*BYTE_W-1:0] addr_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                valid_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             room;

  assign room = (cnt_q < CNT_W'(N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= fire_addr_i & room;
      if (fire_cmd_i)               cnt_q <= '0;
      else if (fire_addr_i && room) cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   lane_q <= '0;
      else if (fire_cmd_i)                           lane_q <= '0;
      else if (fire_addr_i && cnt_q == CNT_W'(g))    lane_q <= byte_i;
    end
    assign addr_o[g*BYTE_W +: BYTE_W] = lane_q;
  end

  assign cnt_o = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N)); // R4
  AST_CMD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_cmd_i |=> (cnt_q == '0 && addr_o == '0)); // R4
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_addr_i && !room) |=> (!valid_o && $stable(addr_o))); // R4
endmodule

// File: rtl/nand_fe_read.sv
module nand_fe_read
  import nand_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_s_i,
  input  logic              re_s_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              rd_pop_o,
  output logic [BYTE_W-1:0] io_o,
  output logic              io_oe_o
);
  logic re_prev_q;
  logic pop;

  assign pop = ~ce_s_i & ~re_s_i & re_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_prev_q <= 1'b1;
      rd_pop_o  <= 1'b0;
      io_o      <= '0;
      io_oe_o   <= 1'b0;
    end else begin
      re_prev_q <= re_s_i;
      rd_pop_o  <= pop;
      io_oe_o   <= ~ce_s_i & ~re_s_i;
      if (pop) io_o <= rd_data_i;
    end
  end

  AST_POP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_o |=> !rd_pop_o); // R8
  AST_POP_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_o |-> io_oe_o); // R9
  AST_HOLD_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_pop_o |-> $stable(io_o)); // R8
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
  import nand_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BYTES  = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                ce_ni,
  input  logic                                cle_i,
  input  logic                                ale_i,
  input  logic                                we_ni,
  input  logic                                re_ni,
  input  logic                                wp_ni,
  input  logic [7:0]                          io_i,
  output logic [7:0]                          io_o,
  output logic                                io_oe_o,
  output logic                                cmd_valid_o,
  output logic [7:0]                          cmd_o,
  output logic                                addr_valid_o,
  output logic [ADDR_BYTES*8-1:0]             addr_o,
  output logic [$clog2(ADDR_BYTES+1)-1:0]     addr_cnt_o,
  output logic                                data_valid_o,
  output logic [7:0]                          data_o,
  output logic                                proto_err_o,
  output logic                                rd_pop_o,
  input  logic [7:0]                          rd_data_i
);
  localparam int PIN_W = 6 + BYTE_W;
  localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, {BYTE_W{1'b0}}};

  logic [PIN_W-1:0]  pins_s;
  logic              ce_s, we_s, re_s, wp_s, cle_s, ale_s;
  logic [BYTE_W-1:0] io_s;
  logic              fire_cmd, fire_addr;
  logic [BYTE_W-1:0] cap_byte;

  nand_fe_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ce_ni, we_ni, re_ni, wp_ni, cle_i, ale_i, io_i}),
    .q_o    (pins_s)
  );

  assign {ce_s, we_s, re_s, wp_s, cle_s, ale_s, io_s} = pins_s;

  nand_fe_capture u_cap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_s_i       (ce_s),
    .we_s_i       (we_s),
    .cle_s_i      (cle_s),
    .ale_s_i      (ale_s),
    .wp_s_i       (wp_s),
    .io_s_i       (io_s),
    .fire_cmd_o   (fire_cmd),
    .fire_addr_o  (fire_addr),
    .byte_o       (cap_byte),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_o        (cmd_o),
    .data_valid_o (data_valid_o),
    .data_o       (data_o),
    .err_o        (proto_err_o)
  );

  nand_fe_addr #(.N(ADDR_BYTES)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_cmd_i  (fire_cmd),
    .fire_addr_i (fire_addr),
    .byte_i      (cap_byte),
    .addr_o      (addr_o),
    .cnt_o       (addr_cnt_o),
    .valid_o     (addr_valid_o)
  );

  nand_fe_read u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_s_i    (ce_s),
    .re_s_i    (re_s),
    .rd_data_i (rd_data_i),
    .rd_pop_o  (rd_pop_o),
    .io_o      (io_o),
    .io_oe_o   (io_oe_o)
  );

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, addr_valid_o, data_valid_o, proto_err_o})); // R11
  AST_CE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ce_s) |-> !(cmd_valid_o || addr_valid_o || data_valid_o || proto_err_o || rd_pop_o || io_oe_o)); // R7
  AST_ERR_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $stable(addr_cnt_o)); // R6
endmodule

// File: tb/sim_nand_bus_front.sv
module sim_nand_bus_front;
  localparam int S = 2;
  localparam int N = 5;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #5 clk = ~clk;

  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b0;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_o, cmd_o, data_o, rd_data;
  logic io_oe, cmd_v, addr_v, data_v, err, pop;
  logic [N*8-1:0] addr_o;
  logic [CW-1:0] cnt_o;

  int ptr = 0;
  int compared = 0, mismatched = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  function automatic logic [7:0] pb(int i);
    return 8'((i * 37 + 90) & 255);
  endfunction

  assign rd_data = pb(ptr);

  nand_bus_front #(.SYNC_STAGES(S), .ADDR_BYTES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .we_ni(we_n), .re_ni(re_n), .wp_ni(wp_n), .io_i(io_in), .io_o(io_o),
    .io_oe_o(io_oe), .cmd_valid_o(cmd_v), .cmd_o(cmd_o), .addr_valid_o(addr_v),
    .addr_o(addr_o), .addr_cnt_o(cnt_o), .data_valid_o(data_v), .data_o(data_o),
    .proto_err_o(err), .rd_pop_o(pop), .rd_data_i(rd_data)
  );

  // page buffer environment
  always @(posedge clk) if (rst_n && pop) ptr <= ptr + 1;

  // reference model: pin history, newest at index 0
  logic h_ce[8], h_we[8], h_re[8], h_wp[8], h_cle[8], h_ale[8];
  logic [7:0] h_io[8];
  logic e_cmd_v, e_addr_v, e_data_v, e_err, e_pop, e_oe;
  logic [7:0] e_cmd, e_data, e_io;
  logic [N*8-1:0] e_addr;
  int e_cnt, rd_k;

  initial begin
    for (int i = 0; i < 8; i++) begin
      h_ce[i] = 1; h_we[i] = 1; h_re[i] = 1; h_wp[i] = 0; h_cle[i] = 0; h_ale[i] = 0; h_io[i] = 0;
    end
    e_cmd_v = 0; e_addr_v = 0; e_data_v = 0; e_err = 0; e_pop = 0; e_oe = 0;
    e_cmd = 0; e_data = 0; e_io = 0; e_addr = '0; e_cnt = 0; rd_k = 0;
  end

  always @(posedge clk) begin
    for (int i = 7; i > 0; i--) begin
      h_ce[i] = h_ce[i-1]; h_we[i] = h_we[i-1]; h_re[i] = h_re[i-1];
      h_wp[i] = h_wp[i-1]; h_cle[i] = h_cle[i-1]; h_ale[i] = h_ale[i-1]; h_io[i] = h_io[i-1];
    end
    h_ce[0] = ce_n; h_we[0] = we_n; h_re[0] = re_n; h_wp[0] = wp_n;
    h_cle[0] = cle; h_ale[0] = ale; h_io[0] = io_in;
    e_cmd_v = 0; e_addr_v = 0; e_data_v = 0; e_err = 0; e_pop = 0;
    if (!rst_n) begin
      e_cmd = 0; e_data = 0; e_io = 0; e_addr = '0; e_cnt = 0; rd_k = 0; e_oe = 0;
    end else begin
      if (!h_ce[S] && h_we[S] && !h_we[S+1]) begin
        if (h_cle[S] && h_ale[S]) e_err = 1;
        else if (h_cle[S]) begin
          e_addr = '0; e_cnt = 0;
          if (!(!h_wp[S] && (h_io[S] == 8'h80 || h_io[S] == 8'h10 ||
                             h_io[S] == 8'h60 || h_io[S] == 8'hD0))) begin
            e_cmd_v = 1; e_cmd = h_io[S];
          end
        end else if (h_ale[S]) begin
          if (e_cnt < N) begin
            e_addr[e_cnt*8 +: 8] = h_io[S]; e_cnt++; e_addr_v = 1;
          end
        end else begin
          e_data_v = 1; e_data = h_io[S];
        end
      end
      if (!h_ce[S] && !h_re[S] && h_re[S+1]) begin
        e_pop = 1; e_io = pb(rd_k); rd_k++;
      end
      e_oe = !h_ce[S] && !h_re[S];
    end
  end

  task automatic cmp(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    cmp("R2", "cmd_valid", cmd_v, e_cmd_v);           // R10 suppression via same model
    if (e_cmd_v) cmp("R2", "cmd", cmd_o, e_cmd);
    cmp("R3", "addr_valid", addr_v, e_addr_v);
    cmp("R4", "addr", addr_o, e_addr);
    cmp("R4", "addr_cnt", cnt_o, e_cnt);
    cmp("R5", "data_valid", data_v, e_data_v);
    if (e_data_v) cmp("R5", "data", data_o, e_data);
    cmp("R6", "proto_err", err, e_err);
    cmp("R8", "rd_pop", pop, e_pop);
    cmp("R8", "io_o", io_o, e_io);
    cmp("R9", "io_oe", io_oe, e_oe);                   // R7 when ce high
    cmp("R11", "strobe_count", int'(cmd_v) + int'(addr_v) + int'(data_v) + int'(err), (cmd_v|addr_v|data_v|err) ? 1 : 0);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic c, logic a, logic [7:0] b);
    @(negedge clk); cle = c; ale = a; io_in = b; we_n = 1'b0;
    idle(3); we_n = 1'b1;
    idle(3); cle = 1'b0; ale = 1'b0;
    idle(2);
  endtask

  task automatic rd();
    @(negedge clk); re_n = 1'b0;
    idle(4); re_n = 1'b1;
    idle(4);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 50000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    idle(4);
    // R1 reset state
    cmp("R1", "strobes", {cmd_v, addr_v, data_v, err, pop, io_oe}, 0);
    cmp("R1", "addr", addr_o, 0);
    cmp("R1", "addr_cnt", cnt_o, 0);
    cmp("R1", "io_o", io_o, 0);
    @(negedge clk); rst_n = 1'b1; wp_n = 1'b1;
    chk_en = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    idle(4);
    wr(1, 0, 8'h00);                                  // R2 command
    for (int i = 0; i < 6; i++) wr(0, 1, 8'(8'h11 * (i + 1)));  // R3, sixth byte dropped R4
    wr(1, 0, 8'h30);                                  // R4 clear
    wr(0, 1, 8'hC3); wr(0, 1, 8'h3C);
    wr(0, 0, 8'hDE); wr(0, 0, 8'hAD); wr(0, 0, 8'h00); // R5 data
    wr(1, 1, 8'h77);                                  // R6 error keeps address
    for (int i = 0; i < 4; i++) rd();                 // R8 consecutive bytes
    @(negedge clk); ce_n = 1'b1; idle(4);             // R7 ignored activity
    wr(1, 0, 8'h90); wr(0, 1, 8'h55); wr(0, 0, 8'h66); rd();
    @(negedge clk); ce_n = 1'b0; idle(4);
    rd();
    wp_n = 1'b0; idle(4);                             // R10 protect
    wr(1, 0, 8'h80); wr(1, 0, 8'h10); wr(1, 0, 8'h70);
    wr(0, 1, 8'hAB); wr(1, 0, 8'h60);                 // suppressed command still clears
    wr(1, 0, 8'hD0); wr(1, 0, 8'hFF);
    wp_n = 1'b1; idle(4);
    wr(1, 0, 8'h80); wr(0, 1, 8'h01);
    @(negedge clk); re_n = 1'b0; idle(6); re_n = 1'b1; idle(6);  // R9 long strobe
    idle(8);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule